// File: doc/BRIEF.md
# Masked Interrupt Register Bank

This block gathers five single-cycle event pulses into a latched, software-visible interrupt set and raises one interrupt line. Each event bit stays latched in a raw status register until software clears it. An enable mask selects which latched events reach the interrupt line. A masked status view shows exactly those bits that currently drive the line.

Software reaches the block through a plain word-addressed register port with a write strobe and a combinational read path. The enable mask is never written directly. One strobe register turns enable bits on and a second one turns them off. Latched events are cleared through a clear register. A force register sets any raw bit as if the hardware had raised it, which lets firmware test its interrupt handling without real traffic.

Top module: `irq_bank`

## Requirements
- R1: After the active-low reset, all raw status bits and all enable bits are zero and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` sets raw bit k at the next clock edge, and the bit stays set after the pulse ends. The bit order is: 0 frame end, 1 FIFO full, 2 FIFO underflow, 3 FIFO empty, 4 FIFO half-empty.
- R3: A write to address 3 (enable-on) sets each enable bit whose write-data bit is 1. Enable bits that receive a 0 keep their value.
- R4: A write to address 4 (enable-off) clears each enable bit whose write-data bit is 1. Enable bits that receive a 0 keep their value.
- R5: A write to address 5 (event clear) clears each raw bit whose write-data bit is 1.
- R6: A write to address 6 (event force) sets each raw bit whose write-data bit is 1.
- R7: If an event pulse and an event clear hit the same bit in the same cycle, the bit is set after that edge.
- R8: Address 1 reads raw AND enable. `irq_o` is high exactly when that masked value is non-zero.
- R9: Address 0 reads the raw bits and address 2 reads the enable bits. Addresses 3 to 7 read zero. Bits 31:5 of every read are zero. Writes to addresses 0, 1 and 2 change nothing, and write-data bits 31:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event pulses, one bit per source |
| reg_addr_i | input | 3 | Word address of the register port |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt line, the OR of the masked status |

## Verification
A hardware event pulse and a software clear of the same raw bit can land in the same cycle, and the event must win. The bench provokes this by driving `evt_i` in the same cycle as a clear write that covers both a bit that is already latched and a bit that is not. It then reads raw status back and expects both bits set. A behavioural reference model, updated on every edge, also checks the read port and `irq_o` on every cycle of the run.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [2:0] {
    SEL_RAW     = 3'd0,
    SEL_MASKED  = 3'd1,
    SEL_EN      = 3'd2,
    SEL_EN_ON   = 3'd3,
    SEL_EN_OFF  = 3'd4,
    SEL_EVT_CLR = 3'd5,
    SEL_EVT_FRC = 3'd6
  } reg_sel_e;

  localparam int unsigned EVT_FRAME_END = 0;
  localparam int unsigned EVT_FULL      = 1;
  localparam int unsigned EVT_UNDERFLOW = 2;
  localparam int unsigned EVT_EMPTY     = 3;
  localparam int unsigned EVT_HALF      = 4;
endpackage

// File: rtl/irq_raw_latch.sv
module irq_raw_latch #(
  parameter int unsigned NUM_EVT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_hw_i,
  input  logic [NUM_EVT-1:0] set_sw_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] raw_o
);
  logic [NUM_EVT-1:0] raw_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         raw_q[k] <= 1'b0;
      else if (set_hw_i[k] || set_sw_i[k]) raw_q[k] <= 1'b1;
      else if (clr_i[k])                   raw_q[k] <= 1'b0;
    end
  end

  assign raw_o = raw_q;

  // R7
  hw_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hw_i != '0) |=> ((raw_q & $past(set_hw_i)) == $past(set_hw_i)));

  // R6
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_sw_i != '0) |=> ((raw_q & $past(set_sw_i)) == $past(set_sw_i)));

  // R5
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_hw_i & ~set_sw_i) != '0)
      |=> ((raw_q & $past(clr_i & ~set_hw_i & ~set_sw_i)) == '0));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned NUM_EVT = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] on_i,
  input  logic [NUM_EVT-1:0] off_i,
  output logic [NUM_EVT-1:0] en_o
);
  logic [NUM_EVT-1:0] en_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q[k] <= 1'b0;
      else if (on_i[k])  en_q[k] <= 1'b1;
      else if (off_i[k]) en_q[k] <= 1'b0;
    end
  end

  assign en_o = en_q;

  // R3
  en_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i != '0) |=> ((en_q & $past(on_i)) == $past(on_i)));

  // R4
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((off_i & ~on_i) != '0) |=> ((en_q & $past(off_i & ~on_i)) == '0));

  // R3
  en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i == '0 && off_i == '0) |=> $stable(en_q));
endmodule

// File: rtl/irq_reg_dec.sv
module irq_reg_dec
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EVT-1:0] raw_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic [NUM_EVT-1:0] masked_i,
  output logic [NUM_EVT-1:0] en_on_o,
  output logic [NUM_EVT-1:0] en_off_o,
  output logic [NUM_EVT-1:0] evt_clr_o,
  output logic [NUM_EVT-1:0] evt_frc_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_EVT-1:0] wbits;
  logic               unused_hi;

  assign wbits     = wdata_i[NUM_EVT-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:NUM_EVT];

  always_comb begin
    en_on_o   = '0;
    en_off_o  = '0;
    evt_clr_o = '0;
    evt_frc_o = '0;
    if (we_i) begin
      case (addr_i)
        ADDR_W'(SEL_EN_ON):   en_on_o   = wbits;
        ADDR_W'(SEL_EN_OFF):  en_off_o  = wbits;
        ADDR_W'(SEL_EVT_CLR): evt_clr_o = wbits;
        ADDR_W'(SEL_EVT_FRC): evt_frc_o = wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(SEL_RAW):    rdata_o = DATA_W'(raw_i);
      ADDR_W'(SEL_MASKED): rdata_o = DATA_W'(masked_i);
      ADDR_W'(SEL_EN):     rdata_o = DATA_W'(en_i);
      default:             rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int unsigned NUM_EVT = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] raw, en, masked;
  logic [NUM_EVT-1:0] en_on, en_off, evt_clr, evt_frc;

  irq_reg_dec #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .wdata_i  (reg_wdata_i),
    .raw_i    (raw),
    .en_i     (en),
    .masked_i (masked),
    .en_on_o  (en_on),
    .en_off_o (en_off),
    .evt_clr_o(evt_clr),
    .evt_frc_o(evt_frc),
    .rdata_o  (reg_rdata_o)
  );

  irq_raw_latch #(.NUM_EVT(NUM_EVT)) u_raw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_hw_i(evt_i),
    .set_sw_i(evt_frc),
    .clr_i   (evt_clr),
    .raw_o   (raw)
  );

  irq_en_reg #(.NUM_EVT(NUM_EVT)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .on_i  (en_on),
    .off_i (en_off),
    .en_o  (en)
  );

  assign masked = raw & en;
  assign irq_o  = |masked;

  // R9
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i <= ADDR_W'(SEL_EN) && evt_i == '0) |=> $stable(raw) && $stable(en));
endmodule

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  irq_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_addr_i(addr),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_raw, m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_raw <= 0;
      m_en  <= 0;
    end else begin
      int clr, frc, on, off;
      clr = (we && addr == 5) ? int'(wdata) & 31 : 0;
      frc = (we && addr == 6) ? int'(wdata) & 31 : 0;
      on  = (we && addr == 3) ? int'(wdata) & 31 : 0;
      off = (we && addr == 4) ? int'(wdata) & 31 : 0;
      m_raw <= ((m_raw & ~clr) | frc | int'(evt)) & 31;
      m_en  <= ((m_en & ~off) | on) & 31;
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_raw;
      1: return m_raw & m_en;
      2: return m_en;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    check("R8 per-cycle irq", int'(irq), ((m_raw & m_en) != 0) ? 1 : 0);
    check("R9 per-cycle rdata", int'(rdata), model_rd(int'(addr)));
    if (cycles > 5000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [4:0] e = '0);
    @(posedge clk); #1;
    we = 1'b1; addr = 3'(a); wdata = d; evt = e;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(posedge clk); #1;
    we = 1'b0; evt = e;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    we = 1'b0; evt = '0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(posedge clk); #1;
    we = 1'b0; evt = '0; addr = 3'(a);
    @(negedge clk);
    check(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", int'(irq), 0);
    rst_n = 1'b1;
    rd(0, 0, "R1 raw after reset");
    rd(2, 0, "R1 enable after reset");
    check("R1 irq after reset", int'(irq), 0);

    pulse(5'h01);
    rd(0, 32'h01, "R2 frame end latched");
    idle(); idle(); idle();
    rd(0, 32'h01, "R2 bit held");
    check("R8 irq masked off", int'(irq), 0);

    wr(3, 32'h01);
    rd(2, 32'h01, "R3 enable on");
    rd(1, 32'h01, "R8 masked");
    check("R8 irq raised", int'(irq), 1);
    wr(3, 32'h0C);
    rd(2, 32'h0D, "R3 zero bits keep");
    wr(4, 32'h05);
    rd(2, 32'h08, "R4 enable off");
    check("R8 irq dropped", int'(irq), 0);

    wr(6, 32'h12);
    rd(0, 32'h13, "R6 force");
    rd(1, 32'h00, "R8 masked none");
    wr(6, 32'h08);
    rd(0, 32'h1B, "R6 force empty bit");
    rd(1, 32'h08, "R8 masked empty");
    check("R8 irq from forced", int'(irq), 1);

    wr(5, 32'h0A);
    rd(0, 32'h11, "R5 clear");
    check("R5 irq after clear", int'(irq), 0);

    wr(5, 32'h05, 5'h05);
    rd(0, 32'h15, "R7 event beats clear");

    wr(0, 32'h1F); wr(1, 32'h1F); wr(2, 32'h1F);
    rd(0, 32'h15, "R9 raw write ignored");
    rd(2, 32'h08, "R9 enable write ignored");
    for (int a = 3; a < 8; a++) rd(a, 0, "R9 write-only reads zero");

    wr(3, 32'hFFFF_FFE0);
    rd(2, 32'h08, "R9 upper write bits ignored");
    wr(6, 32'hFFFF_FFFF);
    rd(0, 32'h1F, "R6 force all");
    wr(3, 32'h1F);
    rd(1, 32'h1F, "R9 masked upper zero");
    wr(5, 32'hFFFF_FFFF);
    rd(0, 32'h00, "R5 clear all");
    check("R5 irq after clear all", int'(irq), 0);

    pulse(5'h10);
    rd(1, 32'h10, "R2 half-empty bit 4");
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    check("R1 irq on async reset", int'(irq), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd(0, 0, "R1 raw after second reset");
    rd(2, 0, "R1 enable after second reset");

    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule